// File: doc/BRIEF.md
# Quadrature Numerically Controlled Oscillator

The block is a synchronous sine/cosine generator that emits one pair of signed samples per clock. A phase register advances every cycle by a frequency word. A separate phase preset input, qualified by a load strobe, places the oscillator at any phase without touching the frequency setting. The output frequency is the clock rate times the frequency word divided by 2^16. The finest step is therefore the clock rate over 65536, and the usable range reaches half the clock rate.

The top bits of the phase go to two identical amplitude channels. The cosine channel adds a quarter period to its address. Each channel holds a computed table of one quarter of a sine wave. The two most significant address bits choose the quadrant: the lower of them mirrors the table index, and the upper one inverts the sign. A small fill controller walks from reset through two fill states (FILL_A, FILL_B) to RUN. The valid flag shows that both output registers carry data derived from real phase values.

Fill controller transitions: reset forces FILL_A. FILL_A goes to FILL_B on the next clock, FILL_B goes to RUN on the next clock, and RUN stays in RUN until the next reset.

Top module: `quad_nco`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs after that edge are `sin_out` = 0, `cos_out` = 0 and `out_valid` = 0, and the phase is cleared to 0.
- R2: After `rst` is released, `out_valid` stays low after the first clock edge and is high after the second. It then stays high until the next reset.
- R3: Without a load, the phase after each clock edge equals the previous phase plus `freq_word`, modulo 2^16.
- R4: A clock edge with `phase_load` high sets the phase to `phase_init`, ignoring `freq_word` for that edge. Accumulation continues from that value on the following edge.
- R5: A new `freq_word` changes only the increment applied at the next edge. The phase already reached is not disturbed.
- R6: The samples present after clock edge k are computed from the phase held just before edge k-1, a fixed two-cycle latency.
- R7: With a = phase[15:8] and v = 31·sin(2π(a+0.5)/256), `sin_out` equals the sign of v times round(|v|), in two's complement.
- R8: `cos_out` follows the R7 formula applied to phase + 0x4000 (modulo 2^16), a quarter period ahead of the sine.
- R9: Neither output ever takes the value -32, so the positive and negative ranges are symmetric (±31).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| freq_word | input | 16 | Phase increment per clock |
| phase_init | input | 16 | Phase preset value |
| phase_load | input | 1 | Loads `phase_init` into the phase register |
| sin_out | output | 6 | Signed sine sample |
| cos_out | output | 6 | Signed cosine sample |
| out_valid | output | 1 | Output pipeline filled since reset |

## Verification
A corrupted phase register cannot hide. Two clocks after the fault, both channels show amplitudes that belong to a different table address. Every later sample stays offset, because each step builds on the last one, so a single wrong addition or a missed load shows up as a lasting mismatch. An error in mirroring or sign shows up within a quarter turn of a sweep, as a broken slope or a flipped half-wave. A fill controller that leaves its states early or late moves the rise of `out_valid` away from the second clock after reset.

// File: rtl/qnco_pkg.sv
package qnco_pkg;

    typedef enum logic [1:0] {
        ST_FILL_A = 2'd0,
        ST_FILL_B = 2'd1,
        ST_RUN    = 2'd2
    } fill_state_e;

    localparam real QNCO_PI = 3.14159265358979323846;

endpackage

// File: rtl/qnco_phase_acc.sv
module qnco_phase_acc #(
    parameter int PH_W   = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PH_W-1:0]   freq_word,
    input  logic [PH_W-1:0]   phase_init,
    input  logic              phase_load,
    output logic [ADDR_W-1:0] phase_msb
);

    logic [PH_W-1:0] phase_q;

    // Phase register: preset wins over accumulation, wraps modulo 2^PH_W.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (phase_load) begin
            phase_q <= phase_init;
        end else begin
            phase_q <= phase_q + freq_word;
        end
    end

    assign phase_msb = phase_q[PH_W-1 -: ADDR_W];

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(phase_load)) |-> (phase_q == PH_W'($past(phase_q) + $past(freq_word)))); // R3

    AST_PHASE_PRESET: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(phase_load)) |-> (phase_q == $past(phase_init))); // R4

endmodule

// File: rtl/qnco_quarter_lut.sv
module qnco_quarter_lut
    import qnco_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 6
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [AMP_W-1:0]  amp
);

    localparam int QTR_W = ADDR_W - 2;
    localparam int DEPTH = 1 << QTR_W;
    localparam int MAG_W = AMP_W - 1;
    localparam int PEAK  = (1 << MAG_W) - 1;
    localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {MAG_W{1'b0}}};

    // Quarter-wave magnitude, sampled at half-step offsets so mirroring is exact.
    function automatic int mag_at(int j);
        real x;
        x = real'(PEAK) * $sin(QNCO_PI * (2.0 * real'(j) + 1.0) / (4.0 * real'(DEPTH)));
        return $rtoi(x + 0.5);
    endfunction

    logic [MAG_W-1:0] rom [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom[g] = MAG_W'(mag_at(g));
    end

    logic [1:0]       quad;
    logic [QTR_W-1:0] idx;
    logic [QTR_W-1:0] rd_idx;

    assign quad   = addr[ADDR_W-1 -: 2];
    assign idx    = addr[QTR_W-1:0];
    assign rd_idx = quad[0] ? ~idx : idx;

    logic [MAG_W-1:0]        mag_q;
    logic                    neg_q;
    logic signed [AMP_W-1:0] mag_ext;

    assign mag_ext = $signed({1'b0, mag_q});

    // Stage 1: table read with quadrant mirroring; stage 2: sign restore.
    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q <= '0;
            neg_q <= 1'b0;
            amp   <= '0;
        end else begin
            mag_q <= rom[rd_idx];
            neg_q <= quad[1];
            amp   <= neg_q ? -mag_ext : mag_ext;
        end
    end

    AST_NO_MOST_NEG: assert property (@(posedge clk) disable iff (rst)
        amp != MOST_NEG); // R9

endmodule

// File: rtl/qnco_fill_ctrl.sv
module qnco_fill_ctrl
    import qnco_pkg::*;
(
    input  logic clk,
    input  logic rst,
    output logic out_valid
);

    fill_state_e state_q;
    fill_state_e state_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_FILL_A;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FILL_A: state_d = ST_FILL_B;
            ST_FILL_B: state_d = ST_RUN;
            ST_RUN:    state_d = ST_RUN;
            default:   state_d = ST_FILL_A;
        endcase
    end

    always_comb begin
        out_valid = (state_q == ST_RUN);
    end

    AST_VALID_STICKY: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> out_valid); // R2

endmodule

// File: rtl/quad_nco.sv
module quad_nco #(
    parameter int PH_W   = 16,
    parameter int ADDR_W = 8,
    parameter int AMP_W  = 6
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [PH_W-1:0]         freq_word,
    input  logic [PH_W-1:0]         phase_init,
    input  logic                    phase_load,
    output logic signed [AMP_W-1:0] sin_out,
    output logic signed [AMP_W-1:0] cos_out,
    output logic                    out_valid
);

    localparam int N_CH    = 2;
    localparam int QUARTER = 1 << (ADDR_W - 2);

    logic [ADDR_W-1:0]       addr_base;
    logic signed [AMP_W-1:0] amp_ch [N_CH];

    qnco_phase_acc #(
        .PH_W   (PH_W),
        .ADDR_W (ADDR_W)
    ) u_acc (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .phase_init (phase_init),
        .phase_load (phase_load),
        .phase_msb  (addr_base)
    );

    // Channel 0 is sine; channel 1 reads a quarter period ahead for cosine.
    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] OFS = (c == 0) ? '0 : ADDR_W'(QUARTER);
        logic [ADDR_W-1:0] ch_addr;
        assign ch_addr = addr_base + OFS;

        qnco_quarter_lut #(
            .ADDR_W (ADDR_W),
            .AMP_W  (AMP_W)
        ) u_lut (
            .clk  (clk),
            .rst  (rst),
            .addr (ch_addr),
            .amp  (amp_ch[c])
        );
    end

    assign sin_out = amp_ch[0];
    assign cos_out = amp_ch[1];

    qnco_fill_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .out_valid (out_valid)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |=> (sin_out == '0 && cos_out == '0 && !out_valid)); // R1

endmodule

// File: tb/quad_nco_bench.sv
module quad_nco_bench;

    localparam real PI = 3.14159265358979323846;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [15:0]        freq_word = '0;
    logic [15:0]        phase_init = '0;
    logic               phase_load = 1'b0;
    logic signed [5:0]  sin_out;
    logic signed [5:0]  cos_out;
    logic               out_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    quad_nco u_quad_nco (
        .clk        (clk),
        .rst        (rst),
        .freq_word  (freq_word),
        .phase_init (phase_init),
        .phase_load (phase_load),
        .sin_out    (sin_out),
        .cos_out    (cos_out),
        .out_valid  (out_valid)
    );

    typedef struct packed {
        logic [15:0] f;
        logic        ld;
        logic [15:0] init;
        logic [15:0] ph_after;
    } vec_t;

    // Stimulus and the phase expected after the edge it is applied on.
    localparam vec_t VEC [16] = '{
        '{16'h0100, 1'b0, 16'h0000, 16'h0100},  // R3
        '{16'h0100, 1'b0, 16'h0000, 16'h0200},  // R3
        '{16'h1000, 1'b0, 16'h0000, 16'h1200},  // R5 new step
        '{16'hF000, 1'b0, 16'h0000, 16'h0200},  // R3 wrap
        '{16'h0000, 1'b1, 16'h4000, 16'h4000},  // R4 preset
        '{16'h0000, 1'b0, 16'h0000, 16'h4000},  // R4 resume
        '{16'h2000, 1'b0, 16'h0000, 16'h6000},  // R5
        '{16'h8000, 1'b0, 16'h0000, 16'hE000},  // half-rate step
        '{16'h8000, 1'b0, 16'h0000, 16'h6000},
        '{16'h3000, 1'b1, 16'hC080, 16'hC080},  // R4 preset ignores step
        '{16'h3000, 1'b0, 16'h0000, 16'hF080},  // R4 resume
        '{16'h3000, 1'b0, 16'h0000, 16'h2080},  // R3 wrap
        '{16'hFFFF, 1'b0, 16'h0000, 16'h207F},
        '{16'h0001, 1'b0, 16'h0000, 16'h2080},
        '{16'h0000, 1'b0, 16'h0000, 16'h2080},
        '{16'h0000, 1'b0, 16'h0000, 16'h2080}
    };

    function automatic int exp_amp(logic [15:0] p, bit cosine);
        logic [15:0] q;
        int a;
        real v;
        int m;
        q = cosine ? p + 16'h4000 : p;
        a = int'(q[15:8]);
        v = 31.0 * $sin(2.0 * PI * (real'(a) + 0.5) / 256.0);
        m = $rtoi(((v < 0.0) ? -v : v) + 0.5);
        return (v < 0.0) ? -m : m;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] e1;
        logic [15:0] e2;

        // Reset state, R1
        repeat (3) tick();
        chk(sin_out == 0, "R1 sin", int'(sin_out), 0);
        chk(cos_out == 0, "R1 cos", int'(cos_out), 0);
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);

        // Fill timing, R2, with a zero step so the phase stays 0
        rst = 1'b0;
        tick();
        chk(out_valid == 1'b0, "R2 first edge", int'(out_valid), 0);
        tick();
        chk(out_valid == 1'b1, "R2 second edge", int'(out_valid), 1);
        chk(int'(sin_out) == exp_amp(16'h0000, 1'b0), "R6 sin at phase 0", int'(sin_out), exp_amp(16'h0000, 1'b0));
        chk(int'(cos_out) == exp_amp(16'h0000, 1'b1), "R6 cos at phase 0", int'(cos_out), exp_amp(16'h0000, 1'b1));

        // Vector walk: output after edge n reflects phase after edge n-2 (R6)
        e1 = 16'h0000;
        e2 = 16'h0000;
        for (int n = 0; n < 16; n++) begin
            freq_word  = VEC[n].f;
            phase_load = VEC[n].ld;
            phase_init = VEC[n].init;
            tick();
            chk(int'(sin_out) == exp_amp(e1, 1'b0), "R7 sin", int'(sin_out), exp_amp(e1, 1'b0));
            chk(int'(cos_out) == exp_amp(e1, 1'b1), "R8 cos", int'(cos_out), exp_amp(e1, 1'b1));
            chk(out_valid == 1'b1, "R2 held", int'(out_valid), 1);
            e1 = e2;
            e2 = VEC[n].ph_after;
            e1 = (n == 0) ? 16'h0000 : e1;
        end
        phase_load = 1'b0;

        // Full-turn sweep: every table address, both channels, R9 range
        freq_word  = 16'h0100;
        phase_load = 1'b1;
        phase_init = 16'h0000;
        tick();
        phase_load = 1'b0;
        for (int m = 1; m < 260; m++) begin
            tick();
            if (m >= 2) begin
                logic [15:0] p;
                p = 16'((m - 2) * 256);
                chk(int'(sin_out) == exp_amp(p, 1'b0), "R7 sweep", int'(sin_out), exp_amp(p, 1'b0));
                chk(int'(cos_out) == exp_amp(p, 1'b1), "R8 sweep", int'(cos_out), exp_amp(p, 1'b1));
                chk(sin_out != -6'sd32 && cos_out != -6'sd32, "R9 range", int'(sin_out), 31);
            end
        end

        // Reset in mid-run, R1, then fill timing again, R2
        rst = 1'b1;
        tick();
        chk(sin_out == 0 && cos_out == 0, "R1 mid-run", int'(sin_out), 0);
        chk(out_valid == 1'b0, "R1 mid-run valid", int'(out_valid), 0);
        freq_word = 16'h0000;
        rst = 1'b0;
        tick();
        chk(out_valid == 1'b0, "R2 refill", int'(out_valid), 0);
        tick();
        chk(out_valid == 1'b1, "R2 refill done", int'(out_valid), 1);
        chk(int'(cos_out) == exp_amp(16'h0000, 1'b1), "R1 phase cleared", int'(cos_out), exp_amp(16'h0000, 1'b1));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule